// File: doc/BRIEF.md
# MSI-to-SPI Doorbell Frame

This block is a memory-mapped frame that turns message-signalled interrupt writes from devices into interrupt pulses. A device posts a 32-bit write to the frame; when the write names a shared peripheral interrupt (SPI) inside the frame's configured window, the frame raises a single-cycle pulse on the matching bit of a one-hot output vector. That vector feeds the edge-sensitive inputs of an interrupt controller, which is outside this block. The frame also answers reads of three registers: a type register that describes its window, an identification word, and a sticky flag recording that an out-of-window write was seen.

Two strap inputs fix the decode. In doorbell mode (`mode_addr_only` = 0) the frame fills a 4 KiB window and the SPI number travels in the data of a write to the doorbell offset. A two-bit adjust strap can make the frame expect the SPI number minus a constant, either the window base or 32, and it adds that constant back before decoding. In address mode (`mode_addr_only` = 1) the frame fills an 8 KiB window and the SPI number is encoded in the write address; the data word and the adjust strap are then ignored. The window (parameters `SPI_BASE`, `SPI_COUNT`) is legal only when the base is at least 32, the count is at least one and base plus count is at most 1019. A frame built with an illegal window accepts writes but raises no pulse.

A small controller sequences the bus port. States: `ST_IDLE` (port ready), `ST_PULSE` (drives the pulse, port not ready) and `ST_READ` (presents read data, port not ready). Transitions: `ST_IDLE` to `ST_PULSE` on an accepted write that decodes to an in-window SPI; `ST_IDLE` to `ST_READ` on an accepted read; `ST_PULSE` to `ST_IDLE` and `ST_READ` to `ST_IDLE` unconditionally after one cycle; every other accepted write keeps the controller in `ST_IDLE`.

Top module: `msi_spi_frame`

## Requirements
- R1: While reset is held and after its release, `spi_pulse` is all zeros, `rsp_valid` is low and `req_ready` is high until the first request.
- R2: A read of byte offset 0x008 returns the type word: bits 25:16 hold `SPI_BASE`, bits 9:0 hold `SPI_COUNT`, all other bits zero.
- R3: A read of byte offset 0xFCC returns the `FRAME_ID` parameter; a write to that offset leaves the value read back unchanged.
- R4: In doorbell mode with adjust strap 00, a write to offset 0x040 whose data equals an SPI number n in [SPI_BASE, SPI_BASE+SPI_COUNT-1] drives `spi_pulse` bit n-SPI_BASE high, with all other bits low, for exactly the one cycle after the write handshake.
- R5: A read of the doorbell offset 0x040 returns zero.
- R6: In address mode, a write to offset ((n-32) << 3) raises SPI n as in R4, whatever the data word and the adjust strap hold.
- R7: In doorbell mode the adjust strap sets the decoded SPI number: 01 adds `SPI_BASE` to the data, 10 adds 32, 00 and 11 use the data unchanged.
- R8: A doorbell write whose decoded SPI lies outside the window raises no pulse and sets the error flag, read as bit 0 of offset 0x010; the flag stays set until reset.
- R9: Two accepted writes to the same SPI give two separate pulses with at least one low cycle between them; `req_ready` is low in the cycle after a write that raises a pulse.
- R10: In doorbell mode a write to any offset other than 0x040 raises no pulse and leaves the error flag clear.
- R11: `rsp_valid` is high for exactly the one cycle after a read handshake, with `req_ready` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_addr_only | input | 1 | Strap: 1 selects address mode, 0 doorbell mode |
| adj_sel | input | 2 | Strap: doorbell data adjust (01 base, 10 thirty-two, else none) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Frame can take a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 13 | Byte offset inside the frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| spi_pulse | output | SPI_COUNT | One-hot interrupt pulse, bit i for SPI SPI_BASE+i |

## Verification
Every cycle the assertions check that the pulse vector is at most one-hot, that a pulse lasts a single cycle and always follows an accepted write, that the port is not ready while a pulse or read response is out, that an out-of-window write never produces a pulse, and that a read response lasts one cycle and follows a read handshake. Which bit pulses for a given data word, address or adjust setting, the contents of the type, identification and error registers, the stickiness of the error flag and the gap between back-to-back pulses can only be shown by the bench's scenarios, which compare each pulse and read response against expected values queued by the driver.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    // Byte address width of the frame: wide enough for the 8 KiB address-mode window.
    localparam int unsigned FRAME_ADDR_W = 13;

    // Register offsets within the frame.
    localparam logic [FRAME_ADDR_W-1:0] OFS_TYPE     = 13'h0008;
    localparam logic [FRAME_ADDR_W-1:0] OFS_ERRFLAG  = 13'h0010;
    localparam logic [FRAME_ADDR_W-1:0] OFS_DOORBELL = 13'h0040;
    localparam logic [FRAME_ADDR_W-1:0] OFS_IDENT    = 13'h0FCC;

    // Legal SPI numbering limits.
    localparam int unsigned SPI_FLOOR   = 32;
    localparam int unsigned SPI_CEILING = 1019;

    // Constant added back by the fixed adjust setting.
    localparam int unsigned ADJ_FIXED_VALUE = 32;

    // Width of each field in the type word.
    localparam int unsigned TYPE_FIELD_W = 10;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'b00,
        ADJ_BASE  = 2'b01,
        ADJ_FIXED = 2'b10,
        ADJ_RSVD  = 2'b11
    } adj_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_READ  = 2'd2
    } frame_state_t;

endpackage

// File: rtl/msi_wr_decode.sv
module msi_wr_decode
    import msi_frame_pkg::*;
#(
    parameter int unsigned SPI_BASE  = 64,
    parameter int unsigned SPI_COUNT = 16,
    parameter int unsigned IDX_W     = 4
) (
    input  logic [FRAME_ADDR_W-1:0] addr,
    input  logic [31:0]             wdata,
    input  logic                    mode_addr_only,
    input  logic [1:0]              adj_sel,
    output logic                    db_hit,
    output logic                    in_range,
    output logic [IDX_W-1:0]        idx
);

    localparam logic [32:0] WIN_LO  = 33'(SPI_BASE);
    localparam logic [32:0] WIN_HI  = 33'(SPI_BASE + SPI_COUNT);
    localparam logic [32:0] ADJ_BSE = 33'(SPI_BASE);
    localparam logic [32:0] ADJ_FIX = 33'(ADJ_FIXED_VALUE);

    logic [32:0] spi_num;

    always_comb begin
        if (mode_addr_only) begin
            // Every write in the 8 KiB window is a doorbell; SPI comes from address bits.
            db_hit  = 1'b1;
            spi_num = 33'(SPI_FLOOR) + 33'(addr[FRAME_ADDR_W-1:3]);
        end else begin
            db_hit = (addr == OFS_DOORBELL);
            unique case (adj_sel_t'(adj_sel))
                ADJ_BASE:  spi_num = {1'b0, wdata} + ADJ_BSE;
                ADJ_FIXED: spi_num = {1'b0, wdata} + ADJ_FIX;
                default:   spi_num = {1'b0, wdata};
            endcase
        end
        in_range = (spi_num >= WIN_LO) && (spi_num < WIN_HI);
        idx      = IDX_W'(spi_num - WIN_LO);
    end

endmodule

// File: rtl/msi_reg_read.sv
module msi_reg_read
    import msi_frame_pkg::*;
#(
    parameter int unsigned SPI_BASE  = 64,
    parameter int unsigned SPI_COUNT = 16,
    parameter logic [31:0] FRAME_ID  = 32'h0A5C_0043
) (
    input  logic [FRAME_ADDR_W-1:0] addr,
    input  logic                    err_flag,
    output logic [31:0]             rdata
);

    localparam logic [TYPE_FIELD_W-1:0] BASE_FIELD  = TYPE_FIELD_W'(SPI_BASE);
    localparam logic [TYPE_FIELD_W-1:0] COUNT_FIELD = TYPE_FIELD_W'(SPI_COUNT);
    localparam int unsigned PAD_W = 16 - TYPE_FIELD_W;
    localparam logic [31:0] TYPE_WORD =
        {{PAD_W{1'b0}}, BASE_FIELD, {PAD_W{1'b0}}, COUNT_FIELD};

    always_comb begin
        unique case (addr)
            OFS_TYPE:    rdata = TYPE_WORD;
            OFS_IDENT:   rdata = FRAME_ID;
            OFS_ERRFLAG: rdata = {31'd0, err_flag};
            default:     rdata = 32'd0;  // doorbell and unused offsets read as zero
        endcase
    end

endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
    import msi_frame_pkg::*;
#(
    parameter int unsigned SPI_BASE  = 64,
    parameter int unsigned SPI_COUNT = 16,
    parameter logic [31:0] FRAME_ID  = 32'h0A5C_0043
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_addr_only,
    input  logic [1:0]              adj_sel,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [FRAME_ADDR_W-1:0] req_addr,
    input  logic [31:0]             req_wdata,
    output logic                    rsp_valid,
    output logic [31:0]             rsp_rdata,
    output logic [SPI_COUNT-1:0]    spi_pulse
);

    localparam int unsigned IDX_W = (SPI_COUNT > 1) ? $clog2(SPI_COUNT) : 1;
    localparam bit WINDOW_OK = (SPI_BASE >= SPI_FLOOR) && (SPI_COUNT >= 1) &&
                               (SPI_BASE + SPI_COUNT <= SPI_CEILING);

    frame_state_t     state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      rdata_q;
    logic             err_q;

    logic             db_hit, in_range;
    logic [IDX_W-1:0] dec_idx;
    logic [31:0]      rd_word;
    logic             wr_take, rd_take, fire, bad;
    logic             pulse_on;

    msi_wr_decode #(
        .SPI_BASE  (SPI_BASE),
        .SPI_COUNT (SPI_COUNT),
        .IDX_W     (IDX_W)
    ) i_decode (
        .addr           (req_addr),
        .wdata          (req_wdata),
        .mode_addr_only (mode_addr_only),
        .adj_sel        (adj_sel),
        .db_hit         (db_hit),
        .in_range       (in_range),
        .idx            (dec_idx)
    );

    msi_reg_read #(
        .SPI_BASE  (SPI_BASE),
        .SPI_COUNT (SPI_COUNT),
        .FRAME_ID  (FRAME_ID)
    ) i_regs (
        .addr     (req_addr),
        .err_flag (err_q),
        .rdata    (rd_word)
    );

    assign wr_take = req_valid && req_ready && req_write;
    assign rd_take = req_valid && req_ready && !req_write;
    assign fire    = wr_take && db_hit && in_range && WINDOW_OK;
    assign bad     = wr_take && db_hit && !(in_range && WINDOW_OK);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire)         state_d = ST_PULSE;
                else if (rd_take) state_d = ST_READ;
            end
            ST_PULSE: state_d = ST_IDLE;
            ST_READ:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured pulse index, read data and sticky error flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (fire)    idx_q   <= dec_idx;
            if (rd_take) rdata_q <= rd_word;
            if (bad)     err_q   <= 1'b1;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        pulse_on  = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_PULSE: pulse_on  = 1'b1;
            ST_READ:  rsp_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    assign rsp_rdata = rdata_q;

    for (genvar g = 0; g < SPI_COUNT; g++) begin : g_pulse
        assign spi_pulse[g] = pulse_on && (idx_q == IDX_W'(g));
    end

    // R4: at most one interrupt line pulses at a time.
    assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spi_pulse));

    // R4: a pulse is always the answer to a write accepted on the previous edge.
    assert_pulse_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_pulse != '0) |-> $past(req_valid && req_ready && req_write));

    // R9: a pulse never lasts more than one cycle.
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_pulse != '0) |=> (spi_pulse == '0));

    // R9: the port refuses requests while a pulse is out.
    assert_busy_on_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_pulse != '0) |-> !req_ready);

    // R8: an out-of-window doorbell write never produces a pulse.
    assert_no_pulse_on_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (spi_pulse == '0));

    // R8: the error flag never clears outside reset.
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R11: a read response follows a read handshake and lasts one cycle.
    assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

// File: tb/test_msi_spi_frame.sv
module test_msi_spi_frame;
    import msi_frame_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 64;
    localparam int CNT  = 16;
    localparam logic [31:0] ID = 32'h0A5C_0043;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_addr_only = 1'b0;
    logic [1:0]  adj_sel = 2'b00;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [CNT-1:0] spi_pulse;

    msi_spi_frame #(.SPI_BASE(BASE), .SPI_COUNT(CNT), .FRAME_ID(ID)) i_msi_spi_frame (
        .clk(clk), .rst_n(rst_n), .mode_addr_only(mode_addr_only), .adj_sel(adj_sel),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .spi_pulse(spi_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        longint val;
        string  tag;
    } item_t;

    item_t pulse_q[$];
    item_t read_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items as pulses and read responses appear.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (spi_pulse != '0) begin
                    if (pulse_q.size() == 0) begin
                        check(1'b0, "R8/R10 unexpected pulse", longint'(spi_pulse), 0);
                    end else begin
                        item_t it;
                        logic [CNT-1:0] e;
                        it = pulse_q.pop_front();
                        e = '0;
                        e[it.val] = 1'b1;
                        check(spi_pulse == e, it.tag, longint'(spi_pulse), longint'(e));
                    end
                end
                if (rsp_valid) begin
                    if (read_q.size() == 0) begin
                        check(1'b0, "R11 unexpected read response", longint'(rsp_rdata), 0);
                    end else begin
                        item_t it;
                        it = read_q.pop_front();
                        check(longint'(rsp_rdata) == it.val, it.tag, longint'(rsp_rdata), it.val);
                    end
                end
            end
        end
    end

    task automatic wr(logic [12:0] a, logic [31:0] d, int exp_idx, string tag);
        if (exp_idx >= 0) pulse_q.push_back('{longint'(exp_idx), tag});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [12:0] a, logic [31:0] exp, string tag);
        read_q.push_back('{longint'(exp), tag});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11 ready low during read response", longint'(req_ready), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(spi_pulse == '0, "R1 pulse low in reset", longint'(spi_pulse), 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid low in reset", longint'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready high after reset", longint'(req_ready), 1);
        check(spi_pulse == '0, "R1 pulse low after reset", longint'(spi_pulse), 0);

        // R2: type word
        rd(13'h008, 32'h0040_0010, "R2 type register");
        // R3: identification, write has no effect
        rd(13'hFCC, ID, "R3 ident before write");
        wr(13'hFCC, 32'hFFFF_FFFF, -1, "R3 write ident");
        rd(13'hFCC, ID, "R3 ident after write");
        // R10: writes elsewhere ignored, no error
        wr(13'h044, 32'd66, -1, "R10 near miss");
        wr(13'h008, 32'd70, -1, "R10 type write");
        rd(13'h010, 32'd0, "R10 error flag still clear");

        // R4: doorbell decode
        wr(13'h040, 32'd64, 0, "R4 first SPI");
        wr(13'h040, 32'd79, 15, "R4 last SPI");
        wr(13'h040, 32'd70, 6, "R4 middle SPI");
        // R5: doorbell reads zero
        rd(13'h040, 32'd0, "R5 doorbell read");

        // R8: out-of-window writes
        wr(13'h040, 32'd80, -1, "R8 above window");
        wr(13'h040, 32'd63, -1, "R8 below window");
        rd(13'h010, 32'd1, "R8 error flag set");
        wr(13'h040, 32'd65, 1, "R8 valid write after error");
        rd(13'h010, 32'd1, "R8 error flag sticky");

        // R9: back-to-back writes to the same SPI
        pulse_q.push_back('{2, "R9 first pulse"});
        pulse_q.push_back('{2, "R9 second pulse"});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h040; req_wdata = 32'd66;
        @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b0, "R9 ready low after pulsing write", longint'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        check(spi_pulse == '0, "R9 gap between pulses", longint'(spi_pulse), 0);
        check(req_ready == 1'b1, "R9 ready back for second write", longint'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;

        // R7: adjust strap
        adj_sel = 2'b01;
        wr(13'h040, 32'd5, 5, "R7 base adjust");
        adj_sel = 2'b10;
        wr(13'h040, 32'd40, 8, "R7 fixed adjust");
        adj_sel = 2'b11;
        wr(13'h040, 32'd67, 3, "R7 reserved adjust uses data");
        adj_sel = 2'b00;

        // R6: address mode, data and adjust ignored
        mode_addr_only = 1'b1;
        adj_sel = 2'b01;
        wr(13'h130, 32'hDEAD_BEEF, 6, "R6 address SPI 70");
        adj_sel = 2'b00;
        wr(13'h178, 32'd0, 15, "R6 address SPI 79");
        wr(13'h100, 32'd77, 0, "R6 address SPI 64");
        wr(13'h1D0, 32'd70, -1, "R6 address out of window");
        wr(13'h040, 32'd70, -1, "R6 doorbell offset is SPI 40");
        rd(13'h008, 32'h0040_0010, "R2 type register in address mode");
        mode_addr_only = 1'b0;

        repeat (5) @(negedge clk);
        check(pulse_q.size() == 0 && read_q.size() == 0, "R4/R11 outstanding expected items",
              longint'(pulse_q.size() + read_q.size()), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule